// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a set of shared external interrupt lines and steers each one onto the interrupt inputs of one of several cores. Each shared line has its own settings:

- a core set, with one bit per core;
- a mode word, which picks the distribution style and the trigger type;
- a mask bit.

A global enable gates the whole unit. All settings are written through a single-cycle command port that carries an opcode, a line index and a data word.

Two distribution styles exist. In rotating style, each new assertion of a line goes to the next core of its core set after the core that took the previous one, wrapping around. A level-held line stays with its core until it drops. In fixed style, a line always goes to the lowest-numbered core in its core set.

Each core sees a vector of interrupt lines. Shared line i appears at position `FIRST_COMMON + i` of that vector, and every other position is held low.

Top module: `irq_spread`

## Requirements
- R1: After a synchronous active-low reset the unit is disabled and every line is masked. Every core set is empty and every line is in rotating, level-triggered mode. The rotation pointer of every line points at core NUM_CORE-1, and all outputs are low.
- R2: No output is asserted until an enable command has been accepted (opcode 1, index and data ignored). Once set, the enable stays set until reset.
- R3: For a forwarded level-triggered line, an input value present at a clock edge appears at the outputs after that same edge. A line that is low at an edge drives no output after it.
- R4: Shared line i drives position FIRST_COMMON+i of a core's vector, which is bits [c*CORE_LINES + FIRST_COMMON + i] of `core_irq`. Positions outside FIRST_COMMON..FIRST_COMMON+NUM_SRC-1 are always low. A line drives at most one core at a time.
- R5: In rotating mode (mode bits [1:0] equal 0), a level line that is asserted and forwardable, and not yet claimed, is claimed by the next core in its core set after its pointer, wrapping around. The pointer then moves to that core. The claim lasts until the input drops, even if the core set changes meanwhile.
- R6: The set-mask command (opcode 4) masks the line when data bit 0 is 1 and unmasks it when the bit is 0. A masked line's outputs go low one cycle after the mask takes hold. Masking leaves the pointer and any live claim in place, so unmasking a line that is still held returns it to the same core.
- R7: A line whose core set is all zeros is never forwarded.
- R8: In fixed mode (mode bits [1:0] not 0), the line goes to the lowest-numbered core of its core set, and the pointer does not move.
- R9: In edge mode (mode bit 4 equal 0), each rising input edge seen while the line is forwardable produces a one-cycle output pulse. In rotating mode each such edge advances the pointer.
- R10: Configuration commands are set-core-set (opcode 2, data [NUM_CORE-1:0]) and set-mode (opcode 3, data bits [1:0] select the distribution style and bit 4 selects level triggering). A command takes effect on the outputs one cycle after the edge that accepts it. Commands with cmd_valid low, opcodes 0, 5, 6 and 7, line indexes of NUM_SRC or more, and the other data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command accepted at this edge when high |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | IDX_W | Shared line index for the command |
| cmd_data | input | DATA_W | Command data word |
| src_irq | input | NUM_SRC | Shared interrupt inputs |
| core_irq | output | NUM_CORE*CORE_LINES | Interrupt vectors of all cores, core c at bits [c*CORE_LINES +: CORE_LINES] |

## Verification
An input change that the design samples at an edge shows at `core_irq` right after that edge. The bench therefore drives inputs on the falling edge and compares the outputs on the next falling edge. A command reaches the outputs one edge later than a line input, because its setting is first stored and only used at the following edge. The directed checks wait one extra falling edge after each command for this reason. A behavioural reference model follows the same edge ordering: it computes the outputs from the old settings and then applies the command. The model's whole output vector is compared on every cycle, both through the directed phases and through a long run of random line and command traffic.

// File: rtl/irq_spread_pkg.sv
// Package irq_spread_pkg
// Shared command encodings and mode-word field positions for the shared
// interrupt distributor. Assumes a command data word of at least 5 bits.
package irq_spread_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ENABLE   = 3'd1,
        OP_SET_CORE = 3'd2,
        OP_SET_MODE = 3'd3,
        OP_SET_MASK = 3'd4
    } spread_op_e;

    localparam int MODE_DIST_LSB = 0;  // distribution style field [1:0]
    localparam int MODE_LVL_BIT  = 4;  // 1 = level triggered

endpackage

// File: rtl/irq_spread_cfg.sv
// Module irq_spread_cfg
// Holds the global enable and the per-line settings (core set, style, trigger
// type, mask). It decodes the command port. Assumes NUM_SRC <= 2**IDX_W and
// DATA_W > MODE_LVL_BIT. Indexes of NUM_SRC or more are ignored.
module irq_spread_cfg
    import irq_spread_pkg::*;
#(
    parameter int NUM_SRC  = 4,
    parameter int NUM_CORE = 4,
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [IDX_W-1:0]             cmd_idx,
    input  logic [DATA_W-1:0]            cmd_data,
    output logic                         en_o,
    output logic [NUM_SRC*NUM_CORE-1:0]  cores_o,
    output logic [NUM_SRC-1:0]           rr_o,
    output logic [NUM_SRC-1:0]           lvl_o,
    output logic [NUM_SRC-1:0]           mask_o
);

    logic en_q;
    logic unused_data_bits;

    // Data bits outside the decoded fields are intentionally dropped.
    assign unused_data_bits = ^cmd_data;

    // Global enable: set by the enable command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cmd_valid && (cmd_op == OP_ENABLE)) begin
            en_q <= 1'b1;
        end
    end

    assign en_o = en_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic                hit;
        logic [NUM_CORE-1:0] cores_q;
        logic [1:0]          dist_q;
        logic                lvl_q;
        logic                mask_q;

        assign hit = cmd_valid && (cmd_idx == MY_IDX);

        // Per-line setting registers, written by the matching command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cores_q <= '0;
                dist_q  <= 2'b00;
                lvl_q   <= 1'b1;
                mask_q  <= 1'b1;
            end else if (hit) begin
                case (cmd_op)
                    OP_SET_CORE: cores_q <= cmd_data[NUM_CORE-1:0];
                    OP_SET_MODE: begin
                        dist_q <= cmd_data[MODE_DIST_LSB +: 2];
                        lvl_q  <= cmd_data[MODE_LVL_BIT];
                    end
                    OP_SET_MASK: mask_q <= cmd_data[0];
                    default: ;
                endcase
            end
        end

        assign cores_o[i*NUM_CORE +: NUM_CORE] = cores_q;
        assign rr_o[i]   = (dist_q == 2'b00);
        assign lvl_o[i]  = lvl_q;
        assign mask_o[i] = mask_q;
    end

endmodule

// File: rtl/irq_spread_lane.sv
// Module irq_spread_lane
// Steering for one shared line. It picks a core (rotating or lowest-fixed),
// keeps the rotation pointer and the level claim, and registers the one-hot
// core grant. Assumes the settings are stable registers from irq_spread_cfg.
module irq_spread_lane #(
    parameter int NUM_CORE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_i,
    input  logic                en_i,
    input  logic                mask_i,
    input  logic [NUM_CORE-1:0] cores_i,
    input  logic                rr_i,
    input  logic                lvl_i,
    output logic [NUM_CORE-1:0] grant_o
);

    localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

    logic                src_q;
    logic                claim_q;
    logic [CW-1:0]       ptr_q;
    logic [NUM_CORE-1:0] grant_q;

    logic                allow;
    logic                rise;
    logic                take;
    logic                fire;
    logic                claim_d;
    logic [CW-1:0]       ptr_d;
    logic [CW-1:0]       tgt;
    logic [CW-1:0]       nxt;
    logic [CW-1:0]       low;
    logic [NUM_CORE-1:0] grant_d;

    // First core of the set after position p, wrapping around.
    function automatic logic [CW-1:0] next_after(input logic [CW-1:0] p,
                                                 input logic [NUM_CORE-1:0] m);
        logic found;
        int   j;
        next_after = p;
        found      = 1'b0;
        for (int k = 1; k <= NUM_CORE; k++) begin
            j = (int'(p) + k) % NUM_CORE;
            if (!found && m[j]) begin
                next_after = j[CW-1:0];
                found      = 1'b1;
            end
        end
    endfunction

    // Lowest-numbered core of the set.
    function automatic logic [CW-1:0] lowest(input logic [NUM_CORE-1:0] m);
        lowest = '0;
        for (int j = NUM_CORE - 1; j >= 0; j--) begin
            if (m[j]) lowest = j[CW-1:0];
        end
    endfunction

    // Core choice and claim bookkeeping for this cycle.
    always_comb begin
        allow   = en_i && !mask_i && (cores_i != '0);
        rise    = src_i && !src_q;
        nxt     = next_after(ptr_q, cores_i);
        low     = lowest(cores_i);
        take    = rr_i && allow && (lvl_i ? (src_i && !claim_q) : rise);
        ptr_d   = take ? nxt : ptr_q;
        fire    = allow && (lvl_i ? src_i : rise);
        tgt     = rr_i ? ptr_d : low;
        claim_d = rr_i && lvl_i && src_i && (claim_q || take);
        grant_d = fire ? (NUM_CORE'(1) << tgt) : '0;
    end

    // Lane state: input history, claim, pointer and the registered grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= 1'b0;
            claim_q <= 1'b0;
            ptr_q   <= CW'(NUM_CORE - 1);
            grant_q <= '0;
        end else begin
            src_q   <= src_i;
            claim_q <= claim_d;
            ptr_q   <= ptr_d;
            grant_q <= grant_d;
        end
    end

    assign grant_o = grant_q;

endmodule

// File: rtl/irq_spread.sv
// Module irq_spread (top)
// Shared interrupt distributor. It routes NUM_SRC shared lines onto positions
// FIRST_COMMON.. of each core's CORE_LINES-wide interrupt vector. Assumes
// FIRST_COMMON + NUM_SRC <= CORE_LINES.
module irq_spread #(
    parameter int NUM_SRC      = 4,
    parameter int NUM_CORE     = 4,
    parameter int CORE_LINES   = 32,
    parameter int FIRST_COMMON = 24,
    parameter int IDX_W        = 8,
    parameter int DATA_W       = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    input  logic [2:0]                     cmd_op,
    input  logic [IDX_W-1:0]               cmd_idx,
    input  logic [DATA_W-1:0]              cmd_data,
    input  logic [NUM_SRC-1:0]             src_irq,
    output logic [NUM_CORE*CORE_LINES-1:0] core_irq
);

    logic                        en_w;
    logic [NUM_SRC*NUM_CORE-1:0] cores_w;
    logic [NUM_SRC-1:0]          rr_w;
    logic [NUM_SRC-1:0]          lvl_w;
    logic [NUM_SRC-1:0]          mask_w;
    logic [NUM_CORE-1:0]         grant_w [NUM_SRC];

    irq_spread_cfg #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CORE (NUM_CORE),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_data  (cmd_data),
        .en_o      (en_w),
        .cores_o   (cores_w),
        .rr_o      (rr_w),
        .lvl_o     (lvl_w),
        .mask_o    (mask_w)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        irq_spread_lane #(
            .NUM_CORE (NUM_CORE)
        ) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_irq[i]),
            .en_i    (en_w),
            .mask_i  (mask_w[i]),
            .cores_i (cores_w[i*NUM_CORE +: NUM_CORE]),
            .rr_i    (rr_w[i]),
            .lvl_i   (lvl_w[i]),
            .grant_o (grant_w[i])
        );
    end

    // Fan the lane grants out onto each core's interrupt vector.
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar l = 0; l < CORE_LINES; l++) begin : g_pos
            if (l >= FIRST_COMMON && l < FIRST_COMMON + NUM_SRC) begin : g_used
                assign core_irq[c*CORE_LINES + l] = grant_w[l - FIRST_COMMON][c];
            end else begin : g_idle
                assign core_irq[c*CORE_LINES + l] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_spread_chk.sv
// Module irq_spread_chk
// Property checker for irq_spread, attached by bind. It watches the settings
// and the core vectors and relates them across one clock.
module irq_spread_chk #(
    parameter int NUM_SRC      = 4,
    parameter int NUM_CORE     = 4,
    parameter int CORE_LINES   = 32,
    parameter int FIRST_COMMON = 24
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SRC-1:0]             src_irq,
    input logic [NUM_CORE*CORE_LINES-1:0] core_irq,
    input logic                           en,
    input logic [NUM_SRC-1:0]             mask,
    input logic [NUM_SRC-1:0]             lvl,
    input logic [NUM_SRC*NUM_CORE-1:0]    cores
);

    function automatic logic [NUM_CORE*CORE_LINES-1:0] used_lines();
        used_lines = '0;
        for (int c = 0; c < NUM_CORE; c++)
            for (int i = 0; i < NUM_SRC; i++)
                used_lines[c*CORE_LINES + FIRST_COMMON + i] = 1'b1;
    endfunction

    localparam logic [NUM_CORE*CORE_LINES-1:0] USED = used_lines();

    // R4: positions outside the shared range never rise.
    p_idle_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq & ~USED) == '0);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [NUM_CORE-1:0] g;
        for (genvar c = 0; c < NUM_CORE; c++) begin : g_bit
            assign g[c] = core_irq[c*CORE_LINES + FIRST_COMMON + i];
        end

        p_one_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(g));

        p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> (g == '0));

        p_level_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[i] && !src_irq[i]) |=> (g == '0));

        p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mask[i] |=> (g == '0));

        p_empty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cores[i*NUM_CORE +: NUM_CORE] == '0) |=> (g == '0));

        p_edge_needs_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl[i] && !src_irq[i]) |=> (g == '0));
    end

endmodule

bind irq_spread irq_spread_chk #(
    .NUM_SRC      (NUM_SRC),
    .NUM_CORE     (NUM_CORE),
    .CORE_LINES   (CORE_LINES),
    .FIRST_COMMON (FIRST_COMMON)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_irq  (src_irq),
    .core_irq (core_irq),
    .en       (en_w),
    .mask     (mask_w),
    .lvl      (lvl_w),
    .cores    (cores_w)
);

// File: tb/irq_spread_tb_top.sv
`timescale 1ns/1ps
// Bench for irq_spread: a behavioural reference model compared every cycle,
// plus directed checks per requirement.
module irq_spread_tb_top;

    localparam int C     = 4;
    localparam int N     = 4;
    localparam int LINES = 32;
    localparam int FIRST = 24;
    localparam int IW    = 8;
    localparam int DW    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [IW-1:0]     cmd_idx = '0;
    logic [DW-1:0]     cmd_data = '0;
    logic [C-1:0]      src_irq = '0;
    logic [N*LINES-1:0] core_irq;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    started  = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    irq_spread #(
        .NUM_SRC (C), .NUM_CORE (N), .CORE_LINES (LINES),
        .FIRST_COMMON (FIRST), .IDX_W (IW), .DATA_W (DW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_idx (cmd_idx), .cmd_data (cmd_data), .src_irq (src_irq),
        .core_irq (core_irq)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    int m_cores [C];
    int m_dist  [C];
    int m_lvl   [C];
    int m_mask  [C];
    int m_claim [C];
    int m_ptr   [C];
    int m_prev  [C];
    bit m_en;
    logic [N*LINES-1:0] m_exp;

    function automatic int nxt_core(input int p, input int m);
        for (int k = 1; k <= N; k++) begin
            if (m[(p + k) % N]) return (p + k) % N;
        end
        return p;
    endfunction

    function automatic int low_core(input int m);
        for (int j = 0; j < N; j++) if (m[j]) return j;
        return 0;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_en = 0;
            m_exp = '0;
            for (int i = 0; i < C; i++) begin
                m_cores[i] = 0; m_dist[i] = 0; m_lvl[i] = 1; m_mask[i] = 1;
                m_claim[i] = 0; m_ptr[i] = N - 1; m_prev[i] = 0;
            end
        end else begin
            m_exp = '0;
            for (int i = 0; i < C; i++) begin
                bit s, ok, rise, fire;
                int tgt;
                s    = src_irq[i];
                ok   = m_en && (m_mask[i] == 0) && (m_cores[i] != 0);
                rise = s && !m_prev[i];
                fire = ok && (m_lvl[i] != 0 ? s : rise);
                if (m_dist[i] == 0) begin
                    if (m_lvl[i] != 0) begin
                        if (s && ok && m_claim[i] == 0) begin
                            m_ptr[i] = nxt_core(m_ptr[i], m_cores[i]);
                            m_claim[i] = 1;
                        end
                        if (!s) m_claim[i] = 0;
                    end else begin
                        m_claim[i] = 0;
                        if (ok && rise) m_ptr[i] = nxt_core(m_ptr[i], m_cores[i]);
                    end
                    tgt = m_ptr[i];
                end else begin
                    m_claim[i] = 0;
                    tgt = low_core(m_cores[i]);
                end
                if (fire) m_exp[tgt*LINES + FIRST + i] = 1'b1;
                m_prev[i] = s;
            end
            if (cmd_valid) begin
                if (cmd_op == 3'd1) m_en = 1;
                else if (cmd_idx < C) begin
                    case (cmd_op)
                        3'd2: m_cores[cmd_idx] = int'(cmd_data[N-1:0]);
                        3'd3: begin
                            m_dist[cmd_idx] = int'(cmd_data[1:0]);
                            m_lvl[cmd_idx]  = int'(cmd_data[4]);
                        end
                        3'd4: m_mask[cmd_idx] = int'(cmd_data[0]);
                        default: ;
                    endcase
                end
            end
        end
    end

    // Whole-vector comparison against the model, every cycle.
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (core_irq !== m_exp) begin
                n_errors++;
                $display("FAIL %s model compare: actual %h expected %h",
                         cur_req, core_irq, m_exp);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk_src(input int s, input int core, input string tag);
        logic [N-1:0] got, exp;
        for (int c = 0; c < N; c++) got[c] = core_irq[c*LINES + FIRST + s];
        exp = (core < 0) ? '0 : (N'(1) << core);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s line %0d cores: actual %b expected %b",
                     tag, s, got, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input int idx, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx[IW-1:0]; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0; cmd_idx = '0; cmd_data = '0;
    endtask

    task automatic pulse_check(input int s, input int core, input string tag);
        src_irq[s] = 1'b0;
        @(negedge clk);
        chk_src(s, -1, "R3");
        src_irq[s] = 1'b1;
        @(negedge clk);
        chk_src(s, core, tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [N*LINES-1:0] used;
        used = '0;
        for (int c = 0; c < N; c++)
            for (int i = 0; i < C; i++) used[c*LINES + FIRST + i] = 1'b1;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (core_irq !== '0) begin
            n_errors++;
            $display("FAIL R1 reset outputs: actual %h expected 0", core_irq);
        end

        cur_req = "R2";
        src_irq[0] = 1'b1;
        send(3'd2, 0, 32'hF);
        send(3'd4, 0, 32'h0);
        @(negedge clk);
        chk_src(0, -1, "R2");

        cur_req = "R5";
        send(3'd1, 0, 32'h0);
        @(negedge clk);
        chk_src(0, 0, "R5");
        pulse_check(0, 1, "R5");
        pulse_check(0, 2, "R5");
        pulse_check(0, 3, "R5");
        pulse_check(0, 0, "R5");
        send(3'd2, 0, 32'hA);
        @(negedge clk);
        chk_src(0, 0, "R5");
        pulse_check(0, 1, "R5");
        pulse_check(0, 3, "R5");
        pulse_check(0, 1, "R5");

        cur_req = "R6";
        send(3'd4, 0, 32'h1);
        @(negedge clk);
        chk_src(0, -1, "R6");
        send(3'd4, 0, 32'h0);
        @(negedge clk);
        chk_src(0, 1, "R6");
        send(3'd4, 0, 32'h1);
        src_irq[0] = 1'b0;
        @(negedge clk);
        src_irq[0] = 1'b1;
        @(negedge clk);
        chk_src(0, -1, "R6");
        send(3'd4, 0, 32'h0);
        @(negedge clk);
        chk_src(0, 3, "R6");

        cur_req = "R7";
        send(3'd4, 1, 32'h0);
        src_irq[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_src(1, -1, "R7");

        cur_req = "R8";
        send(3'd3, 1, 32'hF0F0_FF1E);
        send(3'd2, 1, 32'h6);
        @(negedge clk);
        chk_src(1, 1, "R8");
        pulse_check(1, 1, "R8");

        cur_req = "R9";
        send(3'd2, 2, 32'hF);
        send(3'd3, 2, 32'h0);
        send(3'd4, 2, 32'h0);
        @(negedge clk);
        src_irq[2] = 1'b1;
        @(negedge clk);
        chk_src(2, 0, "R9");
        @(negedge clk);
        chk_src(2, -1, "R9");
        src_irq[2] = 1'b0;
        @(negedge clk);
        src_irq[2] = 1'b1;
        @(negedge clk);
        chk_src(2, 1, "R9");

        cur_req = "R4";
        n_checks++;
        if ((core_irq & ~used) !== '0) begin
            n_errors++;
            $display("FAIL R4 idle positions: actual %h expected 0", core_irq & ~used);
        end
        chk_src(0, 3, "R4");

        cur_req = "R10";
        send(3'd4, 5, 32'h1);
        @(negedge clk);
        chk_src(0, 3, "R10");
        send(3'd5, 0, 32'h1);
        @(negedge clk);
        chk_src(0, 3, "R10");
        cmd_op = 3'd4; cmd_idx = '0; cmd_data = 32'h1;
        @(negedge clk);
        cmd_op = '0; cmd_data = '0;
        @(negedge clk);
        chk_src(0, 3, "R10");

        // Mixed traffic, compared against the model on every cycle.
        for (int k = 0; k < 3000; k++) begin
            src_irq = C'($urandom);
            if (($urandom % 6) == 0) begin
                logic [2:0] op;
                logic [DW-1:0] d;
                op = 3'($urandom % 8);
                d  = DW'($urandom);
                if (op == 3'd4 && ($urandom % 3) != 0) d[0] = 1'b0;
                send(op, int'($urandom % 6), d);
            end else begin
                @(negedge clk);
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule